// File: doc/BRIEF.md
# In-Order Transaction Comparator

This block checks a stream of observed bus records against a stream of predicted records, strictly in arrival order. A predictor feeds predicted records on one valid-qualified port, and the block holds them in a small FIFO. A monitor feeds observed records on a second port. Each observed record is checked against the oldest predicted record still pending. The result is reported as a one-cycle flag and counted in a saturating counter.

A record is one packed word `{addr, dir, data}`. A static compare mask parameter selects the bits that take part in the check. When a check fails, both records are presented on debug ports for one cycle. Two further conditions are flagged and counted rather than left silent. The first is an observed record with nothing pending. The second is a predicted record that arrives while the FIFO is full. The two counters stay visible at all times, so they can be read when a test ends.

Top module: `txn_checker`

## Requirements
- R1: While `rst_n` is low, both counters, all flags and `dbg_valid` are 0, `dbg_exp` and `dbg_act` are 0, and no predicted record is pending.
- R2: A record is `{addr[ADDR_W-1:0], dir, data[DATA_W-1:0]}`, with dir 1 for a write. Predicted records are appended to the FIFO tail. Each observed record is checked against the FIFO head, which is then removed, so records are paired in arrival order.
- R3: When the masked records are equal, `match_pulse` is 1 in the cycle after the observed record is presented, and `match_cnt` rises by one in that same cycle.
- R4: When the masked records differ, `mismatch_pulse` and `dbg_valid` are 1 for that one cycle and `mismatch_cnt` rises by one. `dbg_exp` and `dbg_act` carry the two records in that cycle and are 0 in every other cycle.
- R5: An observed record that arrives with the FIFO empty and no predicted record in the same cycle sets `unexpected_pulse` and `mismatch_pulse` and raises `mismatch_cnt`. It pops nothing, and `dbg_valid` stays 0.
- R6: If a predicted and an observed record arrive in the same cycle while the FIFO is empty, the predicted record is checked directly against the observed one and is not stored.
- R7: A predicted record that arrives with DEPTH records pending and no observed record sets `overflow_pulse` for one cycle and is dropped. If an observed record arrives in the same cycle, the pop happens first and the predicted record is stored.
- R8: Each counter stops at 2^CNT_W-1 and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_valid | input | 1 | Predicted record present this cycle |
| exp_rec | input | ADDR_W+1+DATA_W | Predicted record |
| act_valid | input | 1 | Observed record present this cycle |
| act_rec | input | ADDR_W+1+DATA_W | Observed record |
| match_cnt | output | CNT_W | Saturating count of passed checks |
| mismatch_cnt | output | CNT_W | Saturating count of failed checks and unexpected records |
| match_pulse | output | 1 | One-cycle flag for a passed check |
| mismatch_pulse | output | 1 | One-cycle flag for a failed check or an unexpected record |
| unexpected_pulse | output | 1 | One-cycle flag for an observed record with nothing pending |
| overflow_pulse | output | 1 | One-cycle flag for a dropped predicted record |
| dbg_valid | output | 1 | Debug records valid, on a failed check only |
| dbg_exp | output | ADDR_W+1+DATA_W | Predicted record of the failed check |
| dbg_act | output | ADDR_W+1+DATA_W | Observed record of the failed check |

## Verification
The bench targets the empty-FIFO cases, where a same-cycle pair must be checked directly. A design that stored the record first would report it as unexpected and then leave a stale entry, which shifts every later pairing. It fills the FIFO to DEPTH and then offers one more record, both with and without a same-cycle pop. A wrong full test would either drop a record that fits or overwrite the head, and the later drain would then pair the wrong records. It drives each counter past 2^16-1, where a counter without saturation would wrap to 0. A long random mix also shows whether the debug ports leak data in cycles without a failed check.

// File: rtl/txn_checker.sv
module txn_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W+DATA_W:0] CMP_MASK = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     exp_valid,
  input  logic [ADDR_W+DATA_W:0]   exp_rec,
  input  logic                     act_valid,
  input  logic [ADDR_W+DATA_W:0]   act_rec,
  output logic [CNT_W-1:0]         match_cnt,
  output logic [CNT_W-1:0]         mismatch_cnt,
  output logic                     match_pulse,
  output logic                     mismatch_pulse,
  output logic                     unexpected_pulse,
  output logic                     overflow_pulse,
  output logic                     dbg_valid,
  output logic [ADDR_W+DATA_W:0]   dbg_exp,
  output logic [ADDR_W+DATA_W:0]   dbg_act
);

  localparam int REC_W = ADDR_W + DATA_W + 1;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level;

  logic empty, full, bypass, pop, push, unexp, ovf;
  logic do_cmp, same, hit, miss;
  logic [REC_W-1:0] ref_rec;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign bypass  = act_valid && exp_valid && empty;
  assign pop     = act_valid && !empty;
  assign unexp   = act_valid && empty && !exp_valid;
  assign push    = exp_valid && !bypass && (!full || pop);
  assign ovf     = exp_valid && !bypass && full && !pop;
  assign ref_rec = bypass ? exp_rec : mem[rd_ptr];
  assign same    = ((ref_rec ^ act_rec) & CMP_MASK) == '0;
  assign do_cmp  = bypass || pop;
  assign hit     = do_cmp && same;
  assign miss    = do_cmp && !same;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= exp_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_cnt        <= '0;
      mismatch_cnt     <= '0;
      match_pulse      <= 1'b0;
      mismatch_pulse   <= 1'b0;
      unexpected_pulse <= 1'b0;
      overflow_pulse   <= 1'b0;
      dbg_valid        <= 1'b0;
      dbg_exp          <= '0;
      dbg_act          <= '0;
    end else begin
      match_pulse      <= hit;
      mismatch_pulse   <= miss || unexp;
      unexpected_pulse <= unexp;
      overflow_pulse   <= ovf;
      dbg_valid        <= miss;
      dbg_exp          <= miss ? ref_rec : '0;
      dbg_act          <= miss ? act_rec : '0;
      if (hit && match_cnt != CNT_MAX)
        match_cnt <= match_cnt + 1'b1;
      if ((miss || unexp) && mismatch_cnt != CNT_MAX)
        mismatch_cnt <= mismatch_cnt + 1'b1;
    end
  end

endmodule

module txn_checker_props #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exp_valid,
  input logic             act_valid,
  input logic [CNT_W-1:0] match_cnt,
  input logic [CNT_W-1:0] mismatch_cnt,
  input logic             match_pulse,
  input logic             mismatch_pulse,
  input logic             unexpected_pulse,
  input logic             overflow_pulse,
  input logic             dbg_valid
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_match_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && $past(match_cnt) != TOP) |-> match_cnt == $past(match_cnt) + 1'b1);

  assert_match_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !match_pulse |-> $stable(match_cnt));

  assert_mismatch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch_pulse |-> $stable(mismatch_cnt));

  assert_mismatch_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_pulse && $past(mismatch_cnt) != TOP) |-> mismatch_cnt == $past(mismatch_cnt) + 1'b1);

  assert_unexp_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unexpected_pulse |-> (mismatch_pulse && !dbg_valid && $past(act_valid) && !$past(exp_valid)));

  assert_one_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({match_pulse, mismatch_pulse}));

  assert_dbg_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_valid |-> (mismatch_pulse && $past(act_valid)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_pulse |-> ($past(exp_valid) && !$past(act_valid)));
endmodule

bind txn_checker txn_checker_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .exp_valid(exp_valid), .act_valid(act_valid),
  .match_cnt(match_cnt), .mismatch_cnt(mismatch_cnt), .match_pulse(match_pulse),
  .mismatch_pulse(mismatch_pulse), .unexpected_pulse(unexpected_pulse),
  .overflow_pulse(overflow_pulse), .dbg_valid(dbg_valid)
);

// File: tb/tb_txn_checker.sv
module tb_txn_checker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int RW = 49;
  localparam int SAT = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exp_valid = 1'b0, act_valid = 1'b0;
  logic [RW-1:0] exp_rec = '0, act_rec = '0;
  logic [15:0] match_cnt, mismatch_cnt;
  logic match_pulse, mismatch_pulse, unexpected_pulse, overflow_pulse, dbg_valid;
  logic [RW-1:0] dbg_exp, dbg_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_checker dut (
    .clk(clk), .rst_n(rst_n), .exp_valid(exp_valid), .exp_rec(exp_rec),
    .act_valid(act_valid), .act_rec(act_rec), .match_cnt(match_cnt),
    .mismatch_cnt(mismatch_cnt), .match_pulse(match_pulse),
    .mismatch_pulse(mismatch_pulse), .unexpected_pulse(unexpected_pulse),
    .overflow_pulse(overflow_pulse), .dbg_valid(dbg_valid),
    .dbg_exp(dbg_exp), .dbg_act(dbg_act)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [RW-1:0] q[$];
  int m_mc = 0, m_mm = 0;
  bit m_hit, m_miss, m_unx, m_ovf;
  logic [RW-1:0] m_de, m_da;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_mc = 0; m_mm = 0;
      m_hit = 0; m_miss = 0; m_unx = 0; m_ovf = 0; m_de = '0; m_da = '0;
    end else begin
      bit used;
      logic [RW-1:0] r;
      used = 0; m_hit = 0; m_miss = 0; m_unx = 0; m_ovf = 0; m_de = '0; m_da = '0;
      if (act_valid) begin
        if (q.size() == 0 && !exp_valid) m_unx = 1;
        else begin
          if (q.size() == 0) begin r = exp_rec; used = 1; end
          else r = q.pop_front();
          if (r == act_rec) m_hit = 1;
          else begin m_miss = 1; m_de = r; m_da = act_rec; end
        end
      end
      if (exp_valid && !used) begin
        if (q.size() < DEPTH) q.push_back(exp_rec);
        else m_ovf = 1;
      end
      if (m_hit && m_mc < SAT) m_mc++;
      if ((m_miss || m_unx) && m_mm < SAT) m_mm++;
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, want, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 match_pulse", 64'(match_pulse), 64'(m_hit));
      chk("R3 match_cnt", 64'(match_cnt), 64'(m_mc));
      chk("R4 mismatch_pulse", 64'(mismatch_pulse), 64'(m_miss || m_unx));
      chk("R4 mismatch_cnt", 64'(mismatch_cnt), 64'(m_mm));
      chk("R4 dbg_valid", 64'(dbg_valid), 64'(m_miss));
      chk("R4 dbg_exp", 64'(dbg_exp), 64'(m_de));
      chk("R4 dbg_act", 64'(dbg_act), 64'(m_da));
      chk("R5 unexpected_pulse", 64'(unexpected_pulse), 64'(m_unx));
      chk("R7 overflow_pulse", 64'(overflow_pulse), 64'(m_ovf));
    end
  end

  task automatic drive(bit ev, logic [RW-1:0] er, bit av, logic [RW-1:0] ar);
    exp_valid = ev; exp_rec = er; act_valid = av; act_rec = ar;
    @(negedge clk);
  endtask

  task automatic idle(); drive(0, '0, 0, '0); endtask

  function automatic logic [RW-1:0] mk(int a, bit w, int d);
    return {a[15:0], w, d[31:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 match_cnt", 64'(match_cnt), 0);
    chk("R1 mismatch_cnt", 64'(mismatch_cnt), 0);
    chk("R1 flags", 64'({match_pulse, mismatch_pulse, unexpected_pulse, overflow_pulse, dbg_valid}), 0);
    chk("R1 dbg", 64'(dbg_exp | dbg_act), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 in-order pairing
    for (int i = 0; i < 5; i++) drive(1, mk(16'h100 + i, i[0], 32'hA000 + i), 0, '0);
    for (int i = 0; i < 5; i++) drive(0, '0, 1, mk(16'h100 + i, i[0], 32'hA000 + i));
    idle();
    chk("R2 ordered matches", 64'(match_cnt), 5);

    // R4 mismatches on addr, dir and data
    drive(1, mk(1, 1, 7), 0, '0);
    drive(1, mk(2, 0, 8), 0, '0);
    drive(1, mk(3, 1, 9), 0, '0);
    drive(0, '0, 1, mk(5, 1, 7));
    drive(0, '0, 1, mk(2, 1, 8));
    drive(0, '0, 1, mk(3, 1, 10));
    idle();

    // R5 unexpected with empty FIFO
    drive(0, '0, 1, mk(9, 0, 9));
    drive(0, '0, 1, mk(9, 0, 9));
    idle();
    chk("R5 mismatch count", 64'(mismatch_cnt), 5);

    // R6 same-cycle bypass, match then mismatch, nothing stored
    drive(1, mk(4, 1, 44), 1, mk(4, 1, 44));
    drive(1, mk(4, 1, 44), 1, mk(4, 1, 45));
    drive(0, '0, 1, mk(4, 1, 44));
    idle();
    chk("R6 bypass match", 64'(match_cnt), 6);
    chk("R6 nothing stored", 64'(mismatch_cnt), 7);

    // R7 overflow and full-with-pop
    for (int i = 0; i < DEPTH; i++) drive(1, mk(16'h200 + i, 0, i), 0, '0);
    drive(1, mk(16'h2FF, 0, 99), 0, '0);
    drive(1, mk(16'h300, 1, 1), 1, mk(16'h200, 0, 0));
    for (int i = 1; i < DEPTH; i++) drive(0, '0, 1, mk(16'h200 + i, 0, i));
    drive(0, '0, 1, mk(16'h300, 1, 1));
    idle();
    chk("R7 drain after drop", 64'(match_cnt), 6 + DEPTH + 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit ev, av;
      logic [RW-1:0] er, ar;
      ev = ($urandom % 3) != 0;
      av = ($urandom % 3) != 0;
      er = mk($urandom % 8, $urandom % 2, $urandom % 4);
      if (q.size() > 0) ar = q[0]; else ar = er;
      if ($urandom % 4 == 0) ar[0] = ~ar[0];
      drive(ev, er, av, ar);
    end
    idle();
    while (q.size() > 0) drive(0, '0, 1, q[0]);
    idle();

    // R8 saturation
    for (int i = 0; i < SAT + 3; i++) drive(0, '0, 1, mk(1, 0, 1));
    for (int i = 0; i < SAT + 3; i++) drive(1, mk(2, 1, 2), 1, mk(2, 1, 2));
    idle();
    chk("R8 mismatch_cnt saturated", 64'(mismatch_cnt), SAT);
    chk("R8 match_cnt saturated", 64'(match_cnt), SAT);
    idle();
    finish_run();
  end
endmodule